// File: doc/BRIEF.md
# Segmented Audio DAC Front End

This block turns a two-channel serial audio stream into the control codes for a three-segment converter. Words arrive MSB first on a bit clock, with a left/right clock that tells which channel the current slot carries. Every input is sampled in the system clock domain, and each complete 16-bit word is held per channel.

Each held word is first moved from two's complement to offset binary. It is then cut into three fields. The top byte picks a resistor-string tap, and the analog side uses that tap and the one above it. The middle nibble sets a pulse width, over a 16-cycle frame, that switches between the upper and the lower tap. The bottom nibble gives a pair of complementary trim codes for the level-shift resistors. New field values take effect only at a frame boundary, so a pulse is never cut short or stretched.

Top module: `seg_dac_front`

## Requirements
- R1: Serial data is sampled on each rising edge of `ser_bclk`, MSB first. A slot with `ser_lrck` low belongs to channel 1 (left), and a slot with it high belongs to channel 2 (right).
- R2: A word is complete on the 16th rising bit-clock edge after a change of `ser_lrck`. The edge that sees the change carries bit 15. The completed word replaces the held word of that slot's channel.
- R3: Bits that arrive after the 16th in the same slot are ignored.
- R4: A slot that ends with fewer than 16 bits leaves that channel's held word unchanged.
- R5: The tap index is bits 15..8 of the word with bit 15 inverted. Code 0x8000 gives tap 0, and 0x7FFF gives tap 255.
- R6: The PWM frame is 16 clock cycles. `chN_hi` is high for the first N cycles of each frame, where N is word bits 7..4. If N is 0, it stays low for the whole frame.
- R7: The lower trim code equals word bits 3..0, and the upper trim code is 15 minus that field, so the two always sum to 15.
- R8: The tap and trim outputs change only on the first cycle of a frame, and `chN_hi` rises only on that cycle.
- R9: A synchronous reset gives midscale on both channels (tap 128, `hi` low, upper trim 15, lower trim 0). The first clock after reset begins frame cycle 1, so a full frame spans 16 clocks from then. Until a `ser_lrck` change is seen, no word is captured.
- R10: A word for one channel leaves the other channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bclk | input | 1 | Serial bit clock |
| ser_lrck | input | 1 | Channel select: low = channel 1, high = channel 2 |
| ser_data | input | 1 | Serial audio data, MSB first |
| ch1_tap | output | 8 | Channel 1 string tap index |
| ch1_hi | output | 1 | Channel 1 upper-tap select |
| ch1_trim_up | output | 4 | Channel 1 upper trim code |
| ch1_trim_dn | output | 4 | Channel 1 lower trim code |
| ch2_tap | output | 8 | Channel 2 string tap index |
| ch2_hi | output | 1 | Channel 2 upper-tap select |
| ch2_trim_up | output | 4 | Channel 2 upper trim code |
| ch2_trim_dn | output | 4 | Channel 2 lower trim code |

## Verification
A word can finish on the same clock as the frame boundary, where the held fields move into the active set. In that case the old fields must go out for one more frame, and the new word must appear whole in the next frame. The bench provokes this with a six-clock bit period and an idle gap that grows by one clock between word pairs, so the end of a word sweeps across every frame position. A scoreboard then requires every frame to carry exactly one queued word, with its duty, tap and trims unchanged across all 16 cycles.

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int TAP_W  = 8,
  parameter int PWM_W  = 4,
  parameter int TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bclk,
  input  logic              ser_lrck,
  input  logic              ser_data,
  output logic [TAP_W-1:0]  ch1_tap,
  output logic              ch1_hi,
  output logic [TRIM_W-1:0] ch1_trim_up,
  output logic [TRIM_W-1:0] ch1_trim_dn,
  output logic [TAP_W-1:0]  ch2_tap,
  output logic              ch2_hi,
  output logic [TRIM_W-1:0] ch2_trim_up,
  output logic [TRIM_W-1:0] ch2_trim_dn
);
  localparam int WORD_W = TAP_W + PWM_W + TRIM_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [WORD_W-1:0] SIGN = WORD_W'(1) << (WORD_W - 1);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0]  IDLE = CNT_W'(WORD_W);

  logic              bclk_q, lr_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg, word_l, word_r, act_l, act_r;
  logic [PWM_W-1:0]  frm_cnt;

  wire               bit_rise  = ser_bclk & ~bclk_q;
  wire               slot_new  = ser_lrck != lr_q;
  wire [WORD_W-1:0]  next_sh   = {shreg[WORD_W-2:0], ser_data};
  wire               word_done = bit_rise && !slot_new && bit_cnt == LAST;
  wire               frm_end   = frm_cnt == {PWM_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b0;
      lr_q    <= 1'b0;
      bit_cnt <= IDLE;
      shreg   <= '0;
      word_l  <= '0;
      word_r  <= '0;
      act_l   <= SIGN;
      act_r   <= SIGN;
      frm_cnt <= '0;
    end else begin
      bclk_q  <= ser_bclk;
      frm_cnt <= frm_cnt + 1'b1;
      if (bit_rise) begin
        lr_q <= ser_lrck;
        if (slot_new) begin
          shreg   <= next_sh;
          bit_cnt <= CNT_W'(1);
        end else if (bit_cnt < IDLE) begin
          shreg   <= next_sh;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (word_done) begin
        if (lr_q) word_r <= next_sh;
        else      word_l <= next_sh;
      end
      if (frm_end) begin
        act_l <= word_l ^ SIGN;
        act_r <= word_r ^ SIGN;
      end
    end
  end

  assign ch1_tap     = act_l[WORD_W-1 -: TAP_W];
  assign ch2_tap     = act_r[WORD_W-1 -: TAP_W];
  assign ch1_hi      = act_l[TRIM_W +: PWM_W] > frm_cnt;
  assign ch2_hi      = act_r[TRIM_W +: PWM_W] > frm_cnt;
  assign ch1_trim_dn = act_l[TRIM_W-1:0];
  assign ch2_trim_dn = act_r[TRIM_W-1:0];
  assign ch1_trim_up = ~act_l[TRIM_W-1:0];
  assign ch2_trim_up = ~act_r[TRIM_W-1:0];
endmodule

module seg_dac_front_chk #(
  parameter int TAP_W  = 8,
  parameter int PWM_W  = 4,
  parameter int TRIM_W = 4,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [PWM_W-1:0]  frm_cnt,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [TAP_W-1:0]  ch1_tap,
  input logic              ch1_hi,
  input logic [TRIM_W-1:0] ch1_trim_up,
  input logic [TRIM_W-1:0] ch1_trim_dn,
  input logic [TAP_W-1:0]  ch2_tap,
  input logic              ch2_hi,
  input logic [TRIM_W-1:0] ch2_trim_up,
  input logic [TRIM_W-1:0] ch2_trim_dn
);
  localparam int WORD_W = TAP_W + PWM_W + TRIM_W;
  localparam logic [TAP_W-1:0]    MID_TAP  = TAP_W'(1) << (TAP_W - 1);
  localparam logic [TRIM_W:0]     TRIM_SUM = (TRIM_W + 1)'((1 << TRIM_W) - 1);

  // R3
  bit_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W));

  // R7
  trim_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ch1_trim_up} + {1'b0, ch1_trim_dn} == TRIM_SUM) &&
    ({1'b0, ch2_trim_up} + {1'b0, ch2_trim_dn} == TRIM_SUM));

  // R8
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_cnt != '0) |-> ($stable(ch1_tap) && $stable(ch1_trim_dn) &&
                         $stable(ch2_tap) && $stable(ch2_trim_dn)));

  // R6
  hi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ch1_hi) || $rose(ch2_hi)) |-> frm_cnt == '0);

  // R9
  reset_mid_chk: assert property (@(posedge clk)
    rst |=> (ch1_tap == MID_TAP && ch2_tap == MID_TAP && !ch1_hi && !ch2_hi &&
             ch1_trim_dn == '0 && ch2_trim_dn == '0));
endmodule

bind seg_dac_front seg_dac_front_chk #(
  .TAP_W(TAP_W), .PWM_W(PWM_W), .TRIM_W(TRIM_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .frm_cnt(frm_cnt), .bit_cnt(bit_cnt),
  .ch1_tap(ch1_tap), .ch1_hi(ch1_hi), .ch1_trim_up(ch1_trim_up), .ch1_trim_dn(ch1_trim_dn),
  .ch2_tap(ch2_tap), .ch2_hi(ch2_hi), .ch2_trim_up(ch2_trim_up), .ch2_trim_dn(ch2_trim_dn)
);

// File: tb/seg_dac_front_bench.sv
module seg_dac_front_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst = 1'b1, ser_bclk = 1'b0, ser_lrck = 1'b0, ser_data = 1'b0;
  logic [7:0] ch1_tap, ch2_tap;
  logic       ch1_hi, ch2_hi;
  logic [3:0] ch1_trim_up, ch1_trim_dn, ch2_trim_up, ch2_trim_dn;

  seg_dac_front u_seg_dac_front (
    .clk(clk), .rst(rst), .ser_bclk(ser_bclk), .ser_lrck(ser_lrck), .ser_data(ser_data),
    .ch1_tap(ch1_tap), .ch1_hi(ch1_hi), .ch1_trim_up(ch1_trim_up), .ch1_trim_dn(ch1_trim_dn),
    .ch2_tap(ch2_tap), .ch2_hi(ch2_hi), .ch2_trim_up(ch2_trim_up), .ch2_trim_dn(ch2_trim_dn)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [20:0] q_l[$], q_r[$];
  localparam logic [20:0] MID = {8'd128, 5'd0, 4'd15, 4'd0};

  // expected frame image: {tap, high cycles, upper trim, lower trim}  (R5 R6 R7)
  function automatic logic [20:0] image(input logic [15:0] w);
    return {~w[15], w[14:8], 1'b0, w[7:4], 4'd15 - w[3:0], w[3:0]};
  endfunction

  task automatic send(input bit lr, input logic [15:0] w, input int nb);
    @(negedge clk);
    ser_lrck = lr;
    for (int i = 0; i < nb; i++) begin
      ser_data = (i < 16) ? w[15-i] : ~ser_data;
      ser_bclk = 1'b0;
      repeat (3) @(negedge clk);
      ser_bclk = 1'b1;
      repeat (3) @(negedge clk);
      if (i == 15) begin
        if (lr) q_r.push_back(image(w));
        else    q_l.push_back(image(w));
      end
    end
    ser_bclk = 1'b0;
  endtask

  // frame phase, restarted by reset
  logic [3:0] ph = 4'd0;
  always @(posedge clk) ph <= rst ? 4'd0 : ph + 4'd1;

  bit          armed = 1'b0;
  bit          seen[2];
  bit          moved[2];
  logic [15:0] fstart[2];
  logic [4:0]  hic[2];
  logic [20:0] prev[2];

  always @(negedge clk) begin
    if (rst) begin
      n_cmp++;
      if (ch1_tap != 8'd128 || ch2_tap != 8'd128 || ch1_hi || ch2_hi) begin
        n_bad++;
        $display("FAIL R9 reset state: taps %0d/%0d hi %b%b, expected 128/128 hi 00",
                 ch1_tap, ch2_tap, ch1_hi, ch2_hi);
      end
    end else begin
      if (ph == 4'd0) armed = 1'b1;
      if (armed) begin
        for (int c = 0; c < 2; c++) begin
          logic [15:0] f;
          logic        h;
          logic [20:0] obs, ex;
          f = c ? {ch2_tap, ch2_trim_up, ch2_trim_dn} : {ch1_tap, ch1_trim_up, ch1_trim_dn};
          h = c ? ch2_hi : ch1_hi;
          if (ph == 4'd0) begin
            fstart[c] = f; hic[c] = {4'd0, h}; moved[c] = 1'b0;
          end else begin
            if (f != fstart[c]) moved[c] = 1'b1;
            hic[c] = hic[c] + {4'd0, h};
          end
          if (ph == 4'd15) begin
            obs = {fstart[c][15:8], hic[c], fstart[c][7:0]};
            n_cmp++;
            if (moved[c]) begin
              n_bad++;
              $display("FAIL R8 ch%0d fields moved inside frame: start %h now %h", c+1, fstart[c], f);
            end
            if (!seen[c]) begin
              n_cmp++;
              if (obs != MID) begin
                n_bad++;
                $display("FAIL R9 ch%0d first frame %h expected %h", c+1, obs, MID);
              end
              seen[c] = 1'b1;
            end else if (obs != prev[c]) begin
              n_cmp++;
              if ((c ? q_r.size() : q_l.size()) == 0) begin
                n_bad++;
                $display("FAIL R4 R10 ch%0d unexpected update %h, expected no change %h", c+1, obs, prev[c]);
              end else begin
                ex = c ? q_r.pop_front() : q_l.pop_front();
                if (obs != ex) begin
                  n_bad++;
                  $display("FAIL R1 R2 R3 R5 R6 R7 ch%0d frame %h expected %h", c+1, obs, ex);
                end
              end
            end
            prev[c] = obs;
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: run incomplete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    send(1'b1, 16'h1234, 16);          // R1 right channel
    send(1'b0, 16'h8000, 16);          // R5 tap 0, duty 0
    send(1'b1, 16'h7FFF, 16);          // R5 tap 255, full fields
    send(1'b0, 16'hA5C3, 20);          // R3 extra bits ignored
    send(1'b1, 16'h0F0F, 10);          // R4 short slot dropped
    send(1'b0, 16'h5A3C, 16);
    send(1'b1, 16'hFFFF, 16);          // R2 next right word after short slot
    for (int k = 0; k < 16; k++) begin // R8 word end sweeps frame boundary
      send(1'b0, 16'h4000 + 16'(k) * 16'h0321, 16);
      send(1'b1, 16'h2000 + 16'(k) * 16'h0123, 16);
      repeat (k) @(negedge clk);
    end
    repeat (80) @(negedge clk);
    n_cmp++;
    if (q_l.size() != 0 || q_r.size() != 0) begin
      n_bad++;
      $display("FAIL R2 words never shown: %0d left %0d right, expected 0 0", q_l.size(), q_r.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule